// File: doc/BRIEF.md
# Select-Gated Synchronous Serial Port

This block is an 8-bit clock-synchronous serial port. A select input lets several devices share one serial bus. A role bit sets the port up as bus master or as slave. The master makes the serial clock from a programmable divider of the system clock. The slave takes the clock from its pad. Both roles shift data out MSB first on the falling clock edge and sample incoming data on the rising edge. After the eighth bit, the received byte is held in a read register and a one-cycle strobe is raised.

The select input passes through a two-flop synchronizer before any logic uses it. In the slave role it works as a chip select. While it is high, the port leaves the bus and ignores clock edges. In the master role a low select means that another master is driving the bus. The port then releases the clock pin and both data pins. It also latches a sticky fault and can raise an interrupt request. The fault does not stop a transfer that is already running. Only a zero mode field stops shifting. The clear rule depends on the role: in the master role software can clear the fault only while select is high, and in the slave role it can clear the fault at any time.

Top module: `selgate_sport`

## Requirements
- R1: After reset, every output enable, `irq` and `rx_valid` are low. Registers at address 0 (control) and address 1 (fault) read as zero.
- R2: Control register (address 0): bits [2:0] are the mode field (non-zero means run), bit 3 is the role (0 master, 1 slave) and bit 4 is the fault route enable. In master role data goes out on pin A and comes in on pin B. In slave role data goes out on pin B and comes in on pin A. The input pin never has its enable asserted.
- R3: In master role the clock idles high. Each half period lasts (divider + 1) system cycles, with the divider value held in the register at address 2. The MSB is on pin A from the load onward. The byte is complete 16·(divider+1) cycles after the load is accepted.
- R4: After the eighth rising clock edge of a byte, `rx_valid` is high for exactly one cycle and `rx_data` carries the received byte. `rx_data` keeps that value until the next byte completes.
- R5: In slave role with select high, pin B output enable is low and clock edges on `sck_i` do not shift or count bits.
- R6: In slave role with select low and a non-zero mode, the external clock shifts data in from pin A and out on pin B, MSB first.
- R7: In master role, a low select releases the clock pin and both data pins. Starting from the synchronized low sample, the fault flag (address 1, bit 0) is set one cycle later.
- R8: A fault raised during a transfer does not stop it: the byte still completes and is strobed.
- R9: Writing zero to the mode field stops shifting at once. No strobe follows for the byte that was cut short, and the next byte after re-enabling transfers normally.
- R10: Writing 0 to fault bit 0 clears the fault only if the role is slave or the synchronized select is high. In master role with select low the write is ignored.
- R11: `irq` follows the fault flag when the route enable is 1 and stays low when it is 0.
- R12: After the fault is cleared in master role with select high, the clock and pin A output enables are asserted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| tx_data | input | 8 | Byte to transmit |
| tx_load | input | 1 | Load transmit byte (starts a master transfer) |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle byte-complete strobe |
| sel_in | input | 1 | Asynchronous select input |
| irq | output | 1 | Bus fault interrupt request |
| sck_i | input | 1 | Serial clock pad input |
| sck_o | output | 1 | Serial clock pad output |
| sck_oe | output | 1 | Serial clock output enable |
| pin_a_i | input | 1 | Data pin A input |
| pin_a_o | output | 1 | Data pin A output |
| pin_a_oe | output | 1 | Data pin A output enable |
| pin_b_i | input | 1 | Data pin B input |
| pin_b_o | output | 1 | Data pin B output |
| pin_b_oe | output | 1 | Data pin B output enable |

## Verification
The checker watches the pad enables on every cycle. It confirms that the enables follow the role and that a slave with select high stays off the bus. It also confirms that a latched fault releases all pads, that a low select in master role sets the fault and keeps it set against clear writes, that the strobe lasts one cycle, and that the interrupt stays masked while routing is off. Some behaviour only the bench scenarios can show. These are the bit order and clock timing of a transfer, the slave ignoring clock edges while deselected, a byte completing beneath a fault, an aborted byte giving no strobe, and drive returning after a clear.

// File: rtl/sgsp_pkg.sv
package sgsp_pkg;
    localparam int REG_W = 8;

    typedef enum logic {
        ROLE_MASTER = 1'b0,
        ROLE_SLAVE  = 1'b1
    } role_e;

    typedef struct packed {
        logic       route;
        role_e      role;
        logic [2:0] mode;
    } ctrl_t;

    localparam logic [1:0] ADDR_CTRL  = 2'd0;
    localparam logic [1:0] ADDR_FAULT = 2'd1;
    localparam logic [1:0] ADDR_DIV   = 2'd2;

    function automatic logic is_run(input ctrl_t c);
        return |c.mode;
    endfunction
endpackage

// File: rtl/sgsp_sync.sv
module sgsp_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '1;
            q    <= '1;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/sgsp_regs.sv
module sgsp_regs
    import sgsp_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [REG_W-1:0] rd_data,
    input  logic             sel_s,
    output ctrl_t            ctrl_q,
    output logic [DIV_W-1:0] div_q,
    output logic             fault_q,
    output logic             irq
);
    logic slave_role;
    logic fault_set;
    logic fault_clr;

    assign slave_role = (ctrl_q.role == ROLE_SLAVE);
    assign fault_set  = !slave_role && !sel_s;
    assign fault_clr  = wr_en && (wr_addr == ADDR_FAULT) && !wr_data[0]
                        && (slave_role || sel_s);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            div_q   <= '0;
            fault_q <= 1'b0;
        end else begin
            if (wr_en && wr_addr == ADDR_CTRL)
                ctrl_q <= ctrl_t'(wr_data[$bits(ctrl_t)-1:0]);
            if (wr_en && wr_addr == ADDR_DIV)
                div_q <= wr_data[DIV_W-1:0];
            if (fault_set)
                fault_q <= 1'b1;
            else if (fault_clr)
                fault_q <= 1'b0;
        end
    end

    assign irq = fault_q && ctrl_q.route;

    always_comb begin
        case (rd_addr)
            ADDR_CTRL:  rd_data = REG_W'(ctrl_q);
            ADDR_FAULT: rd_data = REG_W'(fault_q);
            ADDR_DIV:   rd_data = REG_W'(div_q);
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/sgsp_clkgen.sv
module sgsp_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             start,
    input  logic             done,
    input  logic [DIV_W-1:0] div,
    output logic             sck,
    output logic             busy,
    output logic             fall_ev,
    output logic             rise_ev
);
    logic [DIV_W-1:0] cnt;
    logic             tick;

    assign tick    = busy && (cnt == div);
    assign fall_ev = tick && sck;
    assign rise_ev = tick && !sck;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            busy <= 1'b0;
            sck  <= 1'b1;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            sck  <= 1'b1;
            cnt  <= '0;
        end else if (tick) begin
            cnt <= '0;
            sck <= ~sck;
            if (done) busy <= 1'b0;
        end else if (busy) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sgsp_shifter.sv
module sgsp_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              fall_ev,
    input  logic              rise_ev,
    input  logic              din,
    output logic              dout,
    output logic              idle,
    output logic              last,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid
);
    localparam int BW = $clog2(DATA_W);

    logic [DATA_W-1:0] txs;
    logic [DATA_W-1:0] rxs;
    logic [BW-1:0]     bitcnt;

    assign idle = (bitcnt == '0);
    assign last = (bitcnt == BW'(DATA_W - 1));
    assign dout = txs[DATA_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            txs      <= '0;
            rxs      <= '0;
            bitcnt   <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (!run) begin
                bitcnt <= '0;
            end else if (load) begin
                txs    <= load_data;
                bitcnt <= '0;
            end else begin
                if (fall_ev && !idle)
                    txs <= {txs[DATA_W-2:0], 1'b0};
                if (rise_ev) begin
                    rxs <= {rxs[DATA_W-2:0], din};
                    if (last) begin
                        bitcnt   <= '0;
                        rx_data  <= {rxs[DATA_W-2:0], din};
                        rx_valid <= 1'b1;
                    end else begin
                        bitcnt <= bitcnt + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/selgate_sport.sv
module selgate_sport
    import sgsp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [1:0]        rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_load,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              sel_in,
    output logic              irq,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              pin_a_i,
    output logic              pin_a_o,
    output logic              pin_a_oe,
    input  logic              pin_b_i,
    output logic              pin_b_o,
    output logic              pin_b_oe
);
    ctrl_t            ctrl_q;
    logic [DIV_W-1:0] div_q;
    logic             fault_q;
    logic             is_slave, run, route;
    logic             sel_s, sck_s, pa_s, pb_s, sck_d;
    logic             m_sck, m_busy, m_fall, m_rise, m_start;
    logic             s_fall, s_rise, slave_act;
    logic             fall_ev, rise_ev, sh_load, sh_idle, sh_last, din, dout;

    sgsp_sync #(.WIDTH(4)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sel_in, sck_i, pin_a_i, pin_b_i}),
        .q   ({sel_s, sck_s, pa_s, pb_s})
    );

    sgsp_regs #(.DIV_W(DIV_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .sel_s   (sel_s),
        .ctrl_q  (ctrl_q),
        .div_q   (div_q),
        .fault_q (fault_q),
        .irq     (irq)
    );

    assign is_slave = (ctrl_q.role == ROLE_SLAVE);
    assign run      = is_run(ctrl_q);
    assign route    = ctrl_q.route;

    always_ff @(posedge clk) begin
        if (rst) sck_d <= 1'b1;
        else     sck_d <= sck_s;
    end

    assign s_rise    = sck_s && !sck_d;
    assign s_fall    = !sck_s && sck_d;
    assign slave_act = run && is_slave && !sel_s;
    assign m_start   = tx_load && !is_slave && !m_busy;

    sgsp_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk     (clk),
        .rst     (rst),
        .run     (run && !is_slave),
        .start   (m_start),
        .done    (m_rise && sh_last),
        .div     (div_q),
        .sck     (m_sck),
        .busy    (m_busy),
        .fall_ev (m_fall),
        .rise_ev (m_rise)
    );

    assign fall_ev = is_slave ? (slave_act && s_fall) : m_fall;
    assign rise_ev = is_slave ? (slave_act && s_rise) : m_rise;
    assign sh_load = is_slave ? (tx_load && sh_idle) : m_start;
    assign din     = is_slave ? pa_s : pb_s;

    sgsp_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .load      (sh_load),
        .load_data (tx_data),
        .fall_ev   (fall_ev),
        .rise_ev   (rise_ev),
        .din       (din),
        .dout      (dout),
        .idle      (sh_idle),
        .last      (sh_last),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid)
    );

    assign sck_o    = m_sck;
    assign pin_a_o  = dout;
    assign pin_b_o  = dout;
    assign sck_oe   = run && !is_slave && sel_s && !fault_q;
    assign pin_a_oe = run && !is_slave && sel_s && !fault_q;
    assign pin_b_oe = slave_act && !fault_q;
endmodule

// File: rtl/sgsp_checker.sv
module sgsp_checker (
    input logic clk,
    input logic rst,
    input logic is_slave,
    input logic run,
    input logic sel_s,
    input logic fault_q,
    input logic route,
    input logic irq,
    input logic sck_oe,
    input logic pin_a_oe,
    input logic pin_b_oe,
    input logic rx_valid
);
    p_master_pins_r2: assert property (@(posedge clk) disable iff (rst)
        !is_slave |-> !pin_b_oe);
    p_slave_pins_r2: assert property (@(posedge clk) disable iff (rst)
        is_slave |-> (!pin_a_oe && !sck_oe));
    p_single_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);
    p_slave_float_r5: assert property (@(posedge clk) disable iff (rst)
        (is_slave && sel_s) |-> !pin_b_oe);
    p_fault_latch_r7: assert property (@(posedge clk) disable iff (rst)
        (!is_slave && !sel_s) |=> fault_q);
    p_fault_float_r7: assert property (@(posedge clk) disable iff (rst)
        fault_q |-> (!sck_oe && !pin_a_oe && !pin_b_oe));
    p_halt_r9: assert property (@(posedge clk) disable iff (rst)
        !run |=> !rx_valid);
    p_clear_blocked_r10: assert property (@(posedge clk) disable iff (rst)
        (fault_q && !is_slave && !sel_s) |=> fault_q);
    p_irq_mask_r11: assert property (@(posedge clk) disable iff (rst)
        !route |-> !irq);
    p_irq_cause_r11: assert property (@(posedge clk) disable iff (rst)
        irq |-> fault_q);
endmodule

bind selgate_sport sgsp_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .is_slave (is_slave),
    .run      (run),
    .sel_s    (sel_s),
    .fault_q  (fault_q),
    .route    (route),
    .irq      (irq),
    .sck_oe   (sck_oe),
    .pin_a_oe (pin_a_oe),
    .pin_b_oe (pin_b_oe),
    .rx_valid (rx_valid)
);

// File: tb/selgate_sport_bench.sv
module selgate_sport_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [7:0] tx_data = '0;
    logic       tx_load = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       sel_in = 1'b1;
    logic       irq;
    logic       sck_drv = 1'b1;
    logic       sck_o, sck_oe;
    logic       pa_drv = 1'b1;
    logic       pin_a_o, pin_a_oe;
    logic       pin_b_i;
    logic       pin_b_o, pin_b_oe;
    logic       loop_en = 1'b0;

    int checks = 0;
    int failures = 0;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;

    assign pin_b_i = loop_en ? pin_a_o : 1'b1;

    selgate_sport u_selgate_sport (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .tx_data(tx_data), .tx_load(tx_load),
        .rx_data(rx_data), .rx_valid(rx_valid),
        .sel_in(sel_in), .irq(irq),
        .sck_i(sck_drv), .sck_o(sck_o), .sck_oe(sck_oe),
        .pin_a_i(pa_drv), .pin_a_o(pin_a_o), .pin_a_oe(pin_a_oe),
        .pin_b_i(pin_b_i), .pin_b_o(pin_b_o), .pin_b_oe(pin_b_oe)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: every strobe must match the oldest expected byte.
    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected strobe", int'(rx_data), 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(rx_data == e, "R4 received byte", int'(rx_data), int'(e));
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input logic [7:0] b);
        @(negedge clk);
        tx_data = b; tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    // Master transfer with loopback; checks MSB, idle clock and length.
    task automatic m_xfer(input logic [7:0] b, input int hp);
        int k;
        exp_q.push_back(b);
        load(b);
        k = 1;
        check(pin_a_o == b[7], "R3 MSB first on pin A", int'(pin_a_o), int'(b[7]));
        check(sck_o == 1'b1, "R3 clock high at start", int'(sck_o), 1);
        while (!rx_valid && k < 4000) begin
            @(negedge clk);
            k++;
        end
        check(k == 16 * (hp + 1) + 1, "R3 byte duration", k, 16 * (hp + 1) + 1);
    endtask

    // Slave byte: bench drives the clock and pin A, samples pin B.
    task automatic s_xfer(input logic [7:0] rxb, input logic [7:0] txb);
        for (int i = 7; i >= 0; i--) begin
            sck_drv = 1'b0;
            pa_drv  = rxb[i];
            wait_n(8);
            check(pin_b_oe && pin_b_o == txb[i], "R6 slave bit on pin B",
                  int'({pin_b_oe, pin_b_o}), int'({1'b1, txb[i]}));
            sck_drv = 1'b1;
            wait_n(8);
        end
    endtask

    initial begin
        #(4 * 150000);
        check(1'b0, "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] v;
        wait_n(3);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(!sck_oe && !pin_a_oe && !pin_b_oe, "R1 enables low",
              int'({sck_oe, pin_a_oe, pin_b_oe}), 0);
        check(!irq && !rx_valid, "R1 irq and strobe low", int'({irq, rx_valid}), 0);
        rd(2'd0, v); check(v == 8'h00, "R1 control reads zero", int'(v), 0);
        rd(2'd1, v); check(v == 8'h00, "R1 fault reads zero", int'(v), 0);

        // Master role, divider 3, loopback from pin A to pin B
        wr(2'd2, 8'd3);
        wr(2'd0, 8'h11);
        loop_en = 1'b1;
        wait_n(4);
        check(sck_oe && pin_a_oe && !pin_b_oe, "R2 master pin roles",
              int'({sck_oe, pin_a_oe, pin_b_oe}), 3'b110);
        m_xfer(8'hA5, 3);
        m_xfer(8'h3C, 3);
        wait_n(20);
        check(rx_data == 8'h3C, "R4 rx_data held", int'(rx_data), 8'h3C);

        // R9: abort mid-byte by clearing the mode field
        load(8'hF0);
        wait_n(20);
        wr(2'd0, 8'h10);
        wait_n(150);
        check(!sck_oe && exp_q.size() == 0, "R9 stopped, no strobe", int'(sck_oe), 0);
        wr(2'd0, 8'h11);
        wait_n(4);
        m_xfer(8'h81, 3);

        // R7: competing master
        sel_in = 1'b0;
        wait_n(3);
        check(!sck_oe && !pin_a_oe && !pin_b_oe, "R7 pins released",
              int'({sck_oe, pin_a_oe, pin_b_oe}), 0);
        rd(2'd1, v); check(v[0] == 1'b1, "R7 fault set", int'(v[0]), 1);
        check(irq == 1'b1, "R11 irq with route on", int'(irq), 1);

        // R11 masking
        wr(2'd0, 8'h01);
        check(irq == 1'b0, "R11 irq masked", int'(irq), 0);
        wr(2'd0, 8'h11);
        check(irq == 1'b1, "R11 irq unmasked", int'(irq), 1);

        // R10: clear refused while select low
        wr(2'd1, 8'h00);
        rd(2'd1, v); check(v[0] == 1'b1, "R10 clear ignored while select low", int'(v[0]), 1);
        sel_in = 1'b1;
        wait_n(4);
        rd(2'd1, v); check(v[0] == 1'b1, "R10 fault sticky", int'(v[0]), 1);
        check(!sck_oe, "R12 still released before clear", int'(sck_oe), 0);
        wr(2'd1, 8'h00);
        rd(2'd1, v); check(v[0] == 1'b0, "R10 clear accepted with select high", int'(v[0]), 0);
        check(sck_oe && pin_a_oe && !irq, "R12 drive restored",
              int'({sck_oe, pin_a_oe, irq}), 3'b110);

        // R8: fault raised during a transfer; byte still completes
        exp_q.push_back(8'h5B);
        load(8'h5B);
        wait_n(20);
        sel_in = 1'b0;
        begin
            int k = 0;
            while (exp_q.size() != 0 && k < 200) begin
                @(negedge clk);
                k++;
            end
            check(exp_q.size() == 0, "R8 byte completed under fault", k, 200);
        end
        rd(2'd1, v); check(v[0] == 1'b1, "R8 fault set during transfer", int'(v[0]), 1);

        // R10: slave role clear accepted with select low
        wr(2'd0, 8'h19);
        wr(2'd1, 8'h00);
        rd(2'd1, v); check(v[0] == 1'b0, "R10 slave clear always accepted", int'(v[0]), 0);

        // R6/R2 slave transfer with select low
        loop_en = 1'b0;
        wait_n(4);
        check(pin_b_oe && !pin_a_oe && !sck_oe, "R2 slave pin roles",
              int'({sck_oe, pin_a_oe, pin_b_oe}), 3'b001);
        load(8'hC3);
        exp_q.push_back(8'h3C);
        s_xfer(8'h3C, 8'hC3);
        wait_n(10);
        check(exp_q.size() == 0, "R6 slave byte strobed", exp_q.size(), 0);

        // R5: deselected slave ignores clock edges
        sel_in = 1'b1;
        wait_n(4);
        check(!pin_b_oe, "R5 pin B released while deselected", int'(pin_b_oe), 0);
        for (int p = 0; p < 3; p++) begin
            sck_drv = 1'b0; pa_drv = 1'b0; wait_n(8);
            sck_drv = 1'b1; wait_n(8);
        end
        check(!pin_b_oe && exp_q.size() == 0, "R5 no activity while deselected",
              int'(pin_b_oe), 0);
        sel_in = 1'b0;
        wait_n(4);
        load(8'h5A);
        exp_q.push_back(8'h96);
        s_xfer(8'h96, 8'h5A);
        wait_n(10);
        check(exp_q.size() == 0, "R5 byte aligned after deselect", exp_q.size(), 0);
        check(rx_data == 8'h96, "R4 slave rx_data held", int'(rx_data), 8'h96);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule